// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters written by a host into asynchronous serial frames on a single output line. The line idles high. Each frame has a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. A baud tick input paces the frame: each bit lasts from one tick to the next. Bit timing is not generated inside the block.

The host sets the format through two small control registers. The main control register holds the two low size bits, the 2-bit parity code and the stop-bit select. The auxiliary register holds the high size bit and the staged ninth data bit. A write to the data byte port takes the byte and the staged ninth bit together into a one-entry holding buffer. The shifter loads that buffer on the next baud tick at which it is idle, or is finishing its last stop bit. The frame format is captured at that moment.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, txd is 1, busy is 0 and buf_empty is 1. The format registers reset to size code 011, parity code 00 and stop select 0, which gives 8 data bits, no parity and one stop bit.
- R2: A data_wr pulse makes buf_empty 0 after that clock edge. No frame begins until a clock edge with baud_tick high, and txd and busy hold their values on every edge without baud_tick.
- R3: A frame drives a 0 start bit, then the data bits least significant first, then parity if enabled, then stop bits at 1. Each bit appears after a tick edge and holds until the next tick edge. busy is 1 from the start bit through the last stop bit.
- R4: The 3-bit size code {aux_size_hi, ctl_size_lo} selects the data bit count: 000=5, 001=6, 010=7, 011=8, 111=9. Codes 100, 101 and 110 give 8.
- R5: ctl_par = 10 appends an even parity bit and 11 appends an odd parity bit. The bit is computed over the data bits actually sent and follows the last data bit.
- R6: ctl_par = 00 and the reserved code 01 both produce frames with no parity bit.
- R7: ctl_two_stop = 1 appends two stop bits and 0 appends one.
- R8: The ninth data bit is taken from the auxiliary register at the moment of the data_wr. Changing that register afterwards does not alter the pending character.
- R9: A format write while a frame is in progress does not alter that frame.
- R10: If a character is pending, the tick that ends the last stop bit starts the next frame directly. txd goes 0, busy stays 1 and buf_empty returns to 1 on that edge.
- R11: A data_wr while the buffer is full replaces the pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-time pulse |
| ctl_wr | input | 1 | Write strobe for the main control register |
| ctl_size_lo | input | 2 | Low two bits of the size code |
| ctl_par | input | 2 | Parity code |
| ctl_two_stop | input | 1 | Stop select: 1 gives two stop bits |
| aux_wr | input | 1 | Write strobe for the auxiliary register |
| aux_size_hi | input | 1 | High bit of the size code |
| aux_bit8 | input | 1 | Staged ninth data bit |
| data_wr | input | 1 | Write strobe for the data byte |
| data_in | input | 8 | Low eight data bits |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | A frame is being shifted out |
| buf_empty | output | 1 | The holding buffer can accept a character |

## Verification
buf_empty is due one edge after a data write. The start bit appears on txd one edge after the first tick that finds the shifter ready. Each later frame bit follows exactly one tick edge after the previous bit, and the idle state returns one tick after the last stop bit. The bench raises baud_tick for exactly one clock edge and samples on the falling edge that follows. This means every comparison lands on the first cycle at which the bit is due, and any extra or missing bit shifts the whole comparison. Format and ninth-bit writes are made between ticks, so the capture points named in R8 and R9 are tested on known edges.

// File: rtl/aft_pkg.sv
package aft_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CHAR_W  = BYTE_W + 1;
  localparam int unsigned REST_W  = CHAR_W + 3;
  localparam int unsigned CNT_W   = $clog2(REST_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_e;

  typedef struct packed {
    logic [2:0] size;
    par_e       par;
    logic       two_stop;
  } fmt_t;

  function automatic logic [CNT_W-1:0] data_bits(input logic [2:0] code);
    case (code)
      3'b000:  data_bits = CNT_W'(5);
      3'b001:  data_bits = CNT_W'(6);
      3'b010:  data_bits = CNT_W'(7);
      3'b111:  data_bits = CNT_W'(9);
      default: data_bits = CNT_W'(8);
    endcase
  endfunction

  function automatic logic par_on(input par_e p);
    par_on = (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                     input logic [CNT_W-1:0] n,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < CHAR_W; i++)
      if (CNT_W'(i) < n) p = p ^ d[i];
    parity_of = p;
  endfunction

  // Bits sent after the start bit.
  function automatic logic [CNT_W-1:0] rest_len(input fmt_t f);
    rest_len = data_bits(f.size) + CNT_W'(par_on(f.par)) + CNT_W'(1)
             + CNT_W'(f.two_stop);
  endfunction

  // Bits after the start bit, first to send in bit 0, stop bits left at 1.
  function automatic logic [REST_W-1:0] rest_bits(input logic [CHAR_W-1:0] d,
                                                  input fmt_t f);
    logic [REST_W-1:0] v;
    logic [CNT_W-1:0]  n;
    v = '1;
    n = data_bits(f.size);
    for (int i = 0; i < CHAR_W; i++)
      if (CNT_W'(i) < n) v[i] = d[i];
    if (par_on(f.par)) v[n] = parity_of(d, n, f.par == PAR_ODD);
    rest_bits = v;
  endfunction
endpackage

// File: rtl/aft_cfg_regs.sv
module aft_cfg_regs
  import aft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_size_lo,
  input  logic [1:0] ctl_par,
  input  logic       ctl_two_stop,
  input  logic       aux_wr,
  input  logic       aux_size_hi,
  input  logic       aux_bit8,
  output fmt_t       fmt,
  output logic       bit8
);
  logic [1:0] size_lo_q;
  par_e       par_q;
  logic       stop_q;
  logic       size_hi_q;
  logic       bit8_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_lo_q <= 2'b11;
      par_q     <= PAR_NONE;
      stop_q    <= 1'b0;
    end else if (ctl_wr) begin
      size_lo_q <= ctl_size_lo;
      par_q     <= par_e'(ctl_par);
      stop_q    <= ctl_two_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_hi_q <= 1'b0;
      bit8_q    <= 1'b0;
    end else if (aux_wr) begin
      size_hi_q <= aux_size_hi;
      bit8_q    <= aux_bit8;
    end
  end

  assign fmt  = '{size: {size_hi_q, size_lo_q}, par: par_q, two_stop: stop_q};
  assign bit8 = bit8_q;
endmodule

// File: rtl/aft_hold_buf.sv
module aft_hold_buf
  import aft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              bit8,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] char_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      char_q <= '0;
    end else begin
      full <= (full && !take) || data_wr;
      if (data_wr) char_q <= {bit8, data_in};
    end
  end
endmodule

// File: rtl/aft_shifter.sv
module aft_shifter
  import aft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              full,
  input  logic [CHAR_W-1:0] char_d,
  input  fmt_t              fmt,
  output logic              take,
  output logic              txd,
  output logic              busy
);
  logic [REST_W-1:0] sreg;
  logic [CNT_W-1:0]  left;
  logic              last_bit;

  assign last_bit = busy && (left == '0);
  assign take     = baud_tick && full && (!busy || last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      sreg <= '1;
      left <= '0;
    end else if (take) begin
      txd  <= 1'b0;
      busy <= 1'b1;
      sreg <= rest_bits(char_d, fmt);
      left <= rest_len(fmt);
    end else if (baud_tick && busy) begin
      if (last_bit) begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end else begin
        txd  <= sreg[0];
        sreg <= {1'b1, sreg[REST_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_size_lo,
  input  logic [1:0] ctl_par,
  input  logic       ctl_two_stop,
  input  logic       aux_wr,
  input  logic       aux_size_hi,
  input  logic       aux_bit8,
  input  logic       data_wr,
  input  logic [7:0] data_in,
  output logic       txd,
  output logic       busy,
  output logic       buf_empty
);
  fmt_t              fmt;
  logic              bit8;
  logic              full;
  logic [CHAR_W-1:0] char_q;
  logic              load_evt;

  aft_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_size_lo(ctl_size_lo), .ctl_par(ctl_par),
    .ctl_two_stop(ctl_two_stop),
    .aux_wr(aux_wr), .aux_size_hi(aux_size_hi), .aux_bit8(aux_bit8),
    .fmt(fmt), .bit8(bit8)
  );

  aft_hold_buf u_buf (
    .clk(clk), .rst_n(rst_n),
    .data_wr(data_wr), .data_in(data_in), .bit8(bit8),
    .take(load_evt), .full(full), .char_q(char_q)
  );

  aft_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .full(full), .char_d(char_q), .fmt(fmt),
    .take(load_evt), .txd(txd), .busy(busy)
  );

  assign buf_empty = !full;
endmodule

// File: rtl/aft_checker.sv
module aft_checker (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic data_wr,
  input logic txd,
  input logic busy,
  input logic buf_empty,
  input logic load_evt
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r2_moves_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> ($stable(txd) && $stable(busy)));

  a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !buf_empty);

  a_r3_load_gives_start: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd && busy));

  a_r2_busy_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!buf_empty));

  a_r10_empty_rises_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(load_evt));
endmodule

bind async_frame_tx aft_checker chk_i (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .data_wr(data_wr),
  .txd(txd), .busy(busy), .buf_empty(buf_empty), .load_evt(load_evt)
);

// File: tb/async_frame_tx_tb_top.sv
module async_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       ctl_wr = 1'b0, aux_wr = 1'b0, data_wr = 1'b0;
  logic [1:0] ctl_size_lo = '0, ctl_par = '0;
  logic       ctl_two_stop = 1'b0, aux_size_hi = 1'b0, aux_bit8 = 1'b0;
  logic [7:0] data_in = '0;
  logic       txd, busy, buf_empty;

  int checks = 0;
  int errors = 0;
  logic cur_hi = 1'b0;
  logic cur_b8 = 1'b0;

  always #2.5 clk = ~clk;

  async_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .ctl_wr(ctl_wr), .ctl_size_lo(ctl_size_lo), .ctl_par(ctl_par),
    .ctl_two_stop(ctl_two_stop), .aux_wr(aux_wr), .aux_size_hi(aux_size_hi),
    .aux_bit8(aux_bit8), .data_wr(data_wr), .data_in(data_in),
    .txd(txd), .busy(busy), .buf_empty(buf_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic set_fmt(input logic [2:0] sz, input logic [1:0] par, input logic stp);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_size_lo = sz[1:0]; ctl_par = par; ctl_two_stop = stp;
    aux_wr = 1'b1; aux_size_hi = sz[2]; aux_bit8 = cur_b8; cur_hi = sz[2];
    @(negedge clk);
    ctl_wr = 1'b0; aux_wr = 1'b0;
  endtask

  task automatic set_b8(input logic b);
    @(negedge clk);
    aux_wr = 1'b1; aux_size_hi = cur_hi; aux_bit8 = b; cur_b8 = b;
    @(negedge clk);
    aux_wr = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    data_wr = 1'b1; data_in = b;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  // Expected line sequence, start bit first.
  task automatic bench_frame(input logic [8:0] d, input logic [2:0] sz,
                             input logic [1:0] par, input logic stp,
                             output logic [15:0] bits, output int len);
    int n;
    logic p;
    if (sz == 3'b111) n = 9;
    else if (sz[2]) n = 8;
    else n = 5 + int'(sz[1:0]);
    bits = '1;
    bits[0] = 1'b0;
    p = (par == 2'b11);
    for (int i = 0; i < n; i++) begin
      bits[1+i] = d[i];
      p = p ^ d[i];
    end
    len = 1 + n;
    if (par[1]) begin bits[len] = p; len++; end
    len += stp ? 2 : 1;
  endtask

  task automatic expect_frame(input string req, input logic [8:0] d,
                              input logic [2:0] sz, input logic [1:0] par,
                              input logic stp, input bit mid_cfg);
    logic [15:0] bits;
    int len;
    bench_frame(d, sz, par, stp, bits, len);
    for (int k = 0; k < len; k++) begin
      tick();
      chk({req, " bit"}, int'(txd), int'(bits[k]));
      chk({req, " busy"}, int'(busy), 1);
      if (mid_cfg && k == 1) set_fmt(~sz, ~par, ~stp);
    end
    tick();
    chk({req, " end txd"}, int'(txd), 1);
    chk({req, " end busy"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1 txd", int'(txd), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 empty", int'(buf_empty), 1);
    put_byte(8'hA5);
    expect_frame("R1 default 8N1", 9'h0A5, 3'b011, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_no_tick();
    put_byte(8'h5A);
    chk("R2 empty after write", int'(buf_empty), 0);
    repeat (5) @(negedge clk);
    chk("R2 txd holds", int'(txd), 1);
    chk("R2 busy holds", int'(busy), 0);
    expect_frame("R3 frame 5A", 9'h05A, 3'b011, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 8; c++) begin
      set_fmt(3'(c), 2'b00, 1'b0);
      put_byte(8'hD3);
      expect_frame($sformatf("R4 size %0d", c), {cur_b8, 8'hD3}, 3'(c), 2'b00, 1'b0, 1'b0);
    end
  endtask

  task automatic t_parity();
    set_b8(1'b1);
    set_fmt(3'b111, 2'b10, 1'b0);
    put_byte(8'h07);
    expect_frame("R5 even 9b", 9'h107, 3'b111, 2'b10, 1'b0, 1'b0);
    set_fmt(3'b111, 2'b11, 1'b0);
    put_byte(8'h07);
    expect_frame("R5 odd 9b", 9'h107, 3'b111, 2'b11, 1'b0, 1'b0);
    set_fmt(3'b000, 2'b11, 1'b0);
    put_byte(8'hF0);
    expect_frame("R5 odd 5b", 9'h1F0, 3'b000, 2'b11, 1'b0, 1'b0);
    set_fmt(3'b011, 2'b01, 1'b0);
    put_byte(8'h01);
    expect_frame("R6 reserved code", 9'h101, 3'b011, 2'b00, 1'b0, 1'b0);
    set_b8(1'b0);
  endtask

  task automatic t_stop2();
    set_fmt(3'b010, 2'b10, 1'b1);
    put_byte(8'h6C);
    expect_frame("R7 two stop", 9'h06C, 3'b010, 2'b10, 1'b1, 1'b0);
  endtask

  task automatic t_bit8();
    set_fmt(3'b111, 2'b00, 1'b0);
    set_b8(1'b1);
    put_byte(8'h00);
    set_b8(1'b0);
    expect_frame("R8 staged ninth bit", 9'h100, 3'b111, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_mid_cfg();
    set_fmt(3'b011, 2'b10, 1'b0);
    put_byte(8'h3C);
    expect_frame("R9 format held", 9'h03C, 3'b011, 2'b10, 1'b0, 1'b1);
  endtask

  task automatic t_back_to_back();
    logic [15:0] a, b;
    int la, lb;
    set_fmt(3'b011, 2'b00, 1'b0);
    bench_frame(9'h0C1, 3'b011, 2'b00, 1'b0, a, la);
    bench_frame(9'h02E, 3'b011, 2'b00, 1'b0, b, lb);
    put_byte(8'hC1);
    tick();
    chk("R10 first start", int'(txd), 0);
    chk("R10 empty after load", int'(buf_empty), 1);
    put_byte(8'h2E);
    for (int k = 1; k < la; k++) begin
      tick();
      chk("R10 first bit", int'(txd), int'(a[k]));
    end
    tick();
    chk("R10 direct start", int'(txd), 0);
    chk("R10 busy kept", int'(busy), 1);
    chk("R10 empty again", int'(buf_empty), 1);
    for (int k = 1; k < lb; k++) begin
      tick();
      chk("R10 second bit", int'(txd), int'(b[k]));
    end
    tick();
    chk("R10 idle", int'(busy), 0);
  endtask

  task automatic t_overwrite();
    put_byte(8'h11);
    put_byte(8'hE2);
    expect_frame("R11 replaced", 9'h0E2, 3'b011, 2'b00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_tick();
    t_sizes();
    t_parity();
    t_stop2();
    t_bit8();
    t_mid_cfg();
    t_back_to_back();
    t_overwrite();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule